// File: doc/BRIEF.md
# Push-Button Debouncer with Press and Release Pulses

This block takes the raw level of a mechanical push button and turns it into clean events in the system clock domain. The input is high while the button is held and low at rest. After a two-stage synchronizer, the level is looked at only on a slow sampling tick. A free-running divider counter produces that tick, once every `TICK_PERIOD` system clocks. The default is 1,000,000 clocks, which is 10 ms at 100 MHz.

The debounced state is held internally and flips only after the sampled level has disagreed with it on two ticks in a row. Contact chatter shorter than one tick period therefore cannot produce a second event. Each flip emits a one-clock pulse: one output marks a press and the other marks a release. A downstream counter can be clocked by the press pulse, and it then advances by exactly one for each physical press.

Top module: `btn_debounce_edges`

## Requirements
- R1: While `rst` is high, and on the cycle after it falls, neither output pulses. Reset leaves the debounced state at released (0), so a button already held at the end of reset yields exactly one press pulse afterwards.
- R2: A press whose bouncing settles within less than one tick period yields exactly one press pulse and no release pulse. A 4-bit counter fed by the press pulse therefore advances by one per press (17 presses take it from 0 to 1).
- R3: The level is sampled once every `TICK_PERIOD` clocks. From a settled released state, a clean rising input gives a press pulse no sooner than `TICK_PERIOD`+2 clocks after the edge.
- R4: The debounced state changes only after two consecutive tick samples disagree with it. A glitch that is seen on at most one tick produces no pulse.
- R5: Each press pulse and each release pulse is high for exactly one clock.
- R6: Press and release pulses are never high in the same cycle.
- R7: A release whose bouncing settles within less than one tick period yields exactly one release pulse and no press pulse.
- R8: After the input settles, the matching pulse appears within 2×`TICK_PERIOD`+4 clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (100 MHz nominal) |
| rst | input | 1 | Synchronous active-high reset |
| btn_raw | input | 1 | Asynchronous button level, 1 = held down |
| press_pulse | output | 1 | One-clock pulse when a press is accepted |
| release_pulse | output | 1 | One-clock pulse when a release is accepted |

## Verification
A corrupted disagreement count or a wrong debounced state shows up at the ports as a missing pulse or an extra one. It is visible within two tick periods of the stimulus that should have produced a pulse: a single-tick glitch then yields a press pulse, or a chattering press yields two. A broken tick divider shows up as latency outside the window from `TICK_PERIOD`+2 to 2×`TICK_PERIOD`+4 clocks. Damaged pulse shaping shows up as a pulse wider than one clock, or as both outputs high together.

// File: rtl/btn_db_pkg.sv
`timescale 1ns/1ps
package btn_db_pkg;

    typedef enum logic {
        BTN_UP   = 1'b0,
        BTN_DOWN = 1'b1
    } btn_level_e;

    typedef struct packed {
        logic press;
        logic release_;
    } btn_evt_t;

    localparam btn_evt_t EVT_NONE = '{press: 1'b0, release_: 1'b0};

    function automatic btn_level_e flip_level(btn_level_e lvl);
        return (lvl == BTN_UP) ? BTN_DOWN : BTN_UP;
    endfunction

    function automatic btn_evt_t evt_for(btn_level_e new_lvl);
        btn_evt_t e;
        e.press    = (new_lvl == BTN_DOWN);
        e.release_ = (new_lvl == BTN_UP);
        return e;
    endfunction

endpackage

// File: rtl/btn_sync.sv
`timescale 1ns/1ps
module btn_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic d_sync
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= d_async;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= {chain_q[STAGES-2:0], d_async};
            end
        end
    endgenerate

    assign d_sync = chain_q[STAGES-1];
endmodule

// File: rtl/btn_tick_gen.sv
`timescale 1ns/1ps
module btn_tick_gen #(
    parameter int unsigned PERIOD = 1_000_000
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int unsigned W = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [W-1:0] LAST = W'(PERIOD - 1);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)               cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                   cnt_q <= cnt_q + 1'b1;
    end

    assign tick = (cnt_q == LAST);

    // R3: the divider never leaves its range
    p_cnt_range_r3: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);

    // R3: ticks are isolated single cycles when the period exceeds one
    p_tick_isolated_r3: assert property (@(posedge clk) disable iff (rst)
        (tick && PERIOD > 1) |=> !tick);
endmodule

// File: rtl/btn_filter.sv
`timescale 1ns/1ps
module btn_filter
    import btn_db_pkg::*;
#(
    parameter int unsigned CONFIRM = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       level,
    output btn_evt_t   evt,
    output btn_level_e state
);
    localparam int unsigned CW = $clog2(CONFIRM + 1);
    localparam logic [CW-1:0] NEED = CW'(CONFIRM - 1);

    btn_level_e  state_q;
    logic [CW-1:0] miss_q;
    btn_evt_t    evt_q;
    logic        disagree;
    logic        accept;

    always_comb begin
        disagree = (btn_level_e'(level) != state_q);
        accept   = tick && disagree && (miss_q == NEED);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= BTN_UP;
            miss_q  <= '0;
            evt_q   <= EVT_NONE;
        end else begin
            evt_q <= EVT_NONE;
            if (tick) begin
                if (!disagree) begin
                    miss_q <= '0;
                end else if (accept) begin
                    state_q <= flip_level(state_q);
                    miss_q  <= '0;
                    evt_q   <= evt_for(flip_level(state_q));
                end else begin
                    miss_q <= miss_q + 1'b1;
                end
            end
        end
    end

    assign evt   = evt_q;
    assign state = state_q;

    // R4: the state only moves on the cycle after a tick
    p_change_on_tick_r4: assert property (@(posedge clk) disable iff (rst)
        !$stable(state_q) |-> $past(tick));

    // R4: the disagreement count stays below the confirm threshold
    p_miss_bound_r4: assert property (@(posedge clk) disable iff (rst)
        miss_q < CW'(CONFIRM));

    // R2: a press pulse coincides with the down state
    p_press_down_r2: assert property (@(posedge clk) disable iff (rst)
        evt_q.press |-> state_q == BTN_DOWN);

    // R7: a release pulse coincides with the up state
    p_release_up_r7: assert property (@(posedge clk) disable iff (rst)
        evt_q.release_ |-> state_q == BTN_UP);

    // R5: pulses are a single clock wide
    p_press_one_r5: assert property (@(posedge clk) disable iff (rst)
        evt_q.press |=> !evt_q.press);
    p_release_one_r5: assert property (@(posedge clk) disable iff (rst)
        evt_q.release_ |=> !evt_q.release_);

    // R6: press and release never overlap
    p_exclusive_r6: assert property (@(posedge clk) disable iff (rst)
        !(evt_q.press && evt_q.release_));
endmodule

// File: rtl/btn_debounce_edges.sv
`timescale 1ns/1ps
module btn_debounce_edges
    import btn_db_pkg::*;
#(
    parameter int unsigned TICK_PERIOD   = 1_000_000,
    parameter int unsigned SYNC_STAGES   = 2,
    parameter int unsigned CONFIRM_TICKS = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic btn_raw,
    output logic press_pulse,
    output logic release_pulse
);
    logic       btn_s;
    logic       tick;
    btn_evt_t   evt;
    btn_level_e db_state;

    btn_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (btn_raw),
        .d_sync  (btn_s)
    );

    btn_tick_gen #(.PERIOD(TICK_PERIOD)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    btn_filter #(.CONFIRM(CONFIRM_TICKS)) u_filter (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .level (btn_s),
        .evt   (evt),
        .state (db_state)
    );

    assign press_pulse   = evt.press;
    assign release_pulse = evt.release_;

    // R1: outputs are quiet on the cycle after a reset cycle
    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!press_pulse && !release_pulse));
endmodule

// File: tb/tb_btn_debounce_edges.sv
`timescale 1ns/1ps
module tb_btn_debounce_edges;
    localparam int unsigned P = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic btn_raw = 1'b0;
    logic press_pulse, release_pulse;

    int n_total = 0;
    int n_fail  = 0;
    int press_n = 0;
    int rel_n   = 0;
    int wide_n  = 0;
    int both_n  = 0;
    logic [3:0] evt_cnt4 = 4'd0;
    logic press_prev = 1'b0;
    logic rel_prev   = 1'b0;
    bit   done = 1'b0;

    always #5 clk = ~clk;

    btn_debounce_edges #(.TICK_PERIOD(P)) dut (
        .clk           (clk),
        .rst           (rst),
        .btn_raw       (btn_raw),
        .press_pulse   (press_pulse),
        .release_pulse (release_pulse)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (press_pulse) begin press_n++; evt_cnt4 <= evt_cnt4 + 4'd1; end
            if (release_pulse) rel_n++;
            if ((press_pulse && press_prev) || (release_pulse && rel_prev)) wide_n++;
            if (press_pulse && release_pulse) both_n++;
        end
        press_prev <= press_pulse;
        rel_prev   <= release_pulse;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bounce_to(input logic lvl);
        // chatter totalling 11 cycles, under one tick period
        btn_raw = lvl;  idle(1);
        btn_raw = ~lvl; idle(3);
        btn_raw = lvl;  idle(2);
        btn_raw = ~lvl; idle(4);
        btn_raw = lvl;  idle(1);
    endtask

    task automatic t_reset();
        rst = 1'b1; btn_raw = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            check(!press_pulse && !release_pulse, "R1 quiet in reset",
                  press_pulse + release_pulse, 0);
        end
        rst = 1'b0;
        @(negedge clk);
        check(!press_pulse && !release_pulse, "R1 quiet after reset",
              press_pulse + release_pulse, 0);
        idle(4 * P);
        check(press_n == 1, "R1 held button gives one press", press_n, 1);
        btn_raw = 1'b0;
        idle(4 * P);
        check(rel_n == 1, "R1 then one release", rel_n, 1);
    endtask

    task automatic t_clean_latency();
        int p0 = press_n;
        int lat = 0;
        idle(3 * P);
        btn_raw = 1'b1;
        for (int i = 1; i <= 3 * P; i++) begin
            @(negedge clk);
            if (press_pulse) begin lat = i; break; end
        end
        check(lat >= P + 2, "R3 latency lower bound", lat, P + 2);
        check(lat != 0 && lat <= 2 * P + 4, "R8 press latency upper bound", lat, 2 * P + 4);
        idle(3 * P);
        check(press_n - p0 == 1, "R2 clean press count", press_n - p0, 1);
        btn_raw = 1'b0;
        lat = 0;
        for (int i = 1; i <= 3 * P; i++) begin
            @(negedge clk);
            if (release_pulse) begin lat = i; break; end
        end
        check(lat != 0 && lat <= 2 * P + 4, "R8 release latency", lat, 2 * P + 4);
        idle(2 * P);
    endtask

    task automatic t_bouncy();
        int p0 = press_n;
        int r0 = rel_n;
        bounce_to(1'b1);
        idle(6 * P);
        check(press_n - p0 == 1, "R2 bouncy press gives one press", press_n - p0, 1);
        check(rel_n == r0, "R2 no release during press", rel_n - r0, 0);
        bounce_to(1'b0);
        idle(6 * P);
        check(rel_n - r0 == 1, "R7 bouncy release gives one release", rel_n - r0, 1);
        check(press_n - p0 == 1, "R7 no press during release", press_n - p0, 1);
    endtask

    task automatic t_glitch();
        int p0 = press_n;
        int r0 = rel_n;
        btn_raw = 1'b1; idle(P - 4);
        btn_raw = 1'b0; idle(5 * P);
        check(press_n == p0, "R4 high glitch ignored", press_n - p0, 0);
        btn_raw = 1'b1; idle(5 * P);
        check(press_n - p0 == 1, "R4 real press after glitch", press_n - p0, 1);
        btn_raw = 1'b0; idle(P - 4);
        btn_raw = 1'b1; idle(5 * P);
        check(rel_n == r0, "R4 low glitch ignored", rel_n - r0, 0);
        btn_raw = 1'b0; idle(5 * P);
        check(rel_n - r0 == 1, "R4 real release after glitch", rel_n - r0, 1);
    endtask

    task automatic t_counter();
        logic [3:0] c0 = evt_cnt4;
        for (int k = 0; k < 17; k++) begin
            bounce_to(1'b1); idle(4 * P);
            bounce_to(1'b0); idle(4 * P);
        end
        check(evt_cnt4 == c0 + 4'd1, "R2 counter after 17 presses",
              int'(evt_cnt4), int'(c0 + 4'd1));
    endtask

    initial begin
        t_reset();
        t_clean_latency();
        t_bouncy();
        t_glitch();
        t_counter();
        check(wide_n == 0, "R5 pulse width one clock", wide_n, 0);
        check(both_n == 0, "R6 pulses never together", both_n, 0);
        check(press_n == rel_n, "R7 releases match presses", rel_n, press_n);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_total++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end
endmodule